// File: doc/BRIEF.md
# Auto-Start Communication Timeout Timer

This block is a down-counting watchdog for a contactless reader's transceive path. It runs from the 13.56 MHz reference clock, divides it by an odd ratio set by a 12-bit prescale value, and counts a 16-bit reload value down towards zero. When it reaches zero it raises a sticky timeout interrupt. The transceive controller uses that interrupt to abandon a frame when no card has answered in time.

The counter is armed in one of two ways. Software can arm it directly through a small byte-wide write port. When auto mode is enabled, the end-of-transmission pulse arms it instead, and the first received response bit stops it again, so that a reply in progress never produces a timeout. With a prescale value of 169, one tick lasts about 25 µs, and a reload of 1000 then gives a timeout of roughly 25 ms.

Register map (byte-wide write port, address in `wrAddr`):

| Address | Contents |
|---|---|
| 0 | Command strobes: bit 0 start, bit 1 stop, bit 2 clear interrupt (write 1 to clear) |
| 1 | Mode: bit 7 auto enable, bits 3:0 high part of the prescale value |
| 2 | Low byte of the prescale value |
| 3 | High byte of the reload value |
| 4 | Low byte of the reload value |

Top module: `tmo_timer`

## Requirements
- R1: After reset, `timerIrq`, `running` and `count` are all zero, and every configuration register is zero.
- R2: A write to address 0 with bit 0 set is a start event. In the cycle after the write, `running` is 1 and `count` equals the reload value {address 3, address 4}, which is the value held before that write cycle.
- R3: While running, `count` falls by exactly one every 2P+1 clock cycles, where P is the 12-bit value {address 1 bits 3:0, address 2}. The first decrement happens 2P+1 cycles after the start edge.
- R4: When `count` reaches zero, `timerIrq` is set and `running` clears. The counter then holds zero and does not reload until the next start event.
- R5: With auto mode on (address 1 bit 7 = 1), a `txDone` pulse is a start event. With auto mode off, `txDone` has no effect on `running` or `count`.
- R6: With auto mode on, an `rxStart` pulse stops the counter. `count` holds its value and no interrupt follows. With auto mode off, `rxStart` is ignored.
- R7: A write to address 0 with bit 1 set stops the counter, and `count` holds its value.
- R8: `timerIrq` stays set until address 0 is written with bit 2 set. A command write with bit 2 clear, or a new start event, leaves it set.
- R9: A start event in the same cycle as a stop wins: the counter loads and runs. An expiry in the same cycle as an interrupt clear leaves `timerIrq` set.
- R10: Starting with a reload value of zero raises `timerIrq` at the first tick, 2P+1 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.56 MHz reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| txDone | input | 1 | End-of-transmission pulse |
| rxStart | input | 1 | First-response-bit pulse |
| timerIrq | output | 1 | Sticky timeout interrupt |
| running | output | 1 | Counter is active |
| count | output | 16 | Current counter value |

## Verification
The assertions check the following on every cycle:
- a start event, whether written or auto-triggered, loads the reload value and sets `running`;
- a stop without a start clears `running`;
- an idle counter holds its value;
- a running counter never moves by more than one step down;
- the interrupt rises only with the counter at zero and stopped;
- the interrupt falls only after a clear write.

Only the bench's scenarios can show the exact 2P+1 tick spacing, the auto-mode gating of `txDone` and `rxStart`, and the two same-cycle priority cases, because these depend on the cycle-exact register history.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  // strobes passed from control to datapath
  typedef struct packed {
    logic load;   // start event: load reload value and run
    logic halt;   // stop event: freeze the counter
  } tmoStrobe_t;

  // register addresses
  localparam int ADDR_CMD    = 0;
  localparam int ADDR_MODE   = 1;
  localparam int ADDR_PRE_LO = 2;
  localparam int ADDR_RLD_HI = 3;
  localparam int ADDR_RLD_LO = 4;

  // command bits
  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
  localparam int CMD_CLR_BIT   = 2;

  // mode bits
  localparam int MODE_AUTO_BIT = 7;

endpackage

// File: rtl/tmo_ctrl.sv
module tmo_ctrl
  import tmo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txDone,
  input  logic              rxStart,
  input  logic              expire,
  output tmoStrobe_t        strobe,
  output logic [PRE_W-1:0]  prescale,
  output logic [CNT_W-1:0]  reload,
  output logic              autoMode,
  output logic              timerIrq
);

  localparam int PRE_HI_W = PRE_W - DATA_W;

  logic [PRE_HI_W-1:0] preHi;
  logic [DATA_W-1:0]   preLo;
  logic [DATA_W-1:0]   rldHi;
  logic [DATA_W-1:0]   rldLo;

  logic cmdWr;
  logic clrEv;

  assign cmdWr = wrEn && (wrAddr == ADDR_W'(ADDR_CMD));
  assign clrEv = cmdWr && wrData[CMD_CLR_BIT];

  always_comb begin
    strobe.load = (cmdWr && wrData[CMD_START_BIT]) || (autoMode && txDone);
    strobe.halt = (cmdWr && wrData[CMD_STOP_BIT])  || (autoMode && rxStart);
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoMode <= 1'b0;
      preHi    <= '0;
      preLo    <= '0;
      rldHi    <= '0;
      rldLo    <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_MODE)) begin
        autoMode <= wrData[MODE_AUTO_BIT];
        preHi    <= wrData[PRE_HI_W-1:0];
      end
      if (wrAddr == ADDR_W'(ADDR_PRE_LO)) preLo <= wrData;
      if (wrAddr == ADDR_W'(ADDR_RLD_HI)) rldHi <= wrData;
      if (wrAddr == ADDR_W'(ADDR_RLD_LO)) rldLo <= wrData;
    end
  end

  // sticky interrupt: expiry wins over a concurrent clear
  always_ff @(posedge clk) begin
    if (!rstN)       timerIrq <= 1'b0;
    else if (expire) timerIrq <= 1'b1;
    else if (clrEv)  timerIrq <= 1'b0;
  end

  assign prescale = {preHi, preLo};
  assign reload   = CNT_W'({rldHi, rldLo});

endmodule

// File: rtl/tmo_datapath.sv
module tmo_datapath
  import tmo_pkg::*;
#(
  parameter int PRE_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmoStrobe_t       strobe,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);

  // the divider counts 0..2P, giving 2P+1 cycles per tick
  localparam int PCNT_W = PRE_W + 1;

  logic [PCNT_W-1:0] preCnt;
  logic [PCNT_W-1:0] term;
  logic              tickHit;
  logic              lastTick;

  assign term     = {prescale, 1'b0};
  assign tickHit  = running && (preCnt >= term);
  assign lastTick = (count <= CNT_W'(1));
  assign expire   = tickHit && lastTick && !strobe.load && !strobe.halt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      count   <= '0;
      running <= 1'b0;
    end else if (strobe.load) begin
      preCnt  <= '0;
      count   <= reload;
      running <= 1'b1;
    end else if (strobe.halt) begin
      running <= 1'b0;
    end else if (running) begin
      if (tickHit) begin
        preCnt <= '0;
        if (lastTick) begin
          count   <= '0;
          running <= 1'b0;
        end else begin
          count <= count - CNT_W'(1);
        end
      end else begin
        preCnt <= preCnt + PCNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tmo_timer.sv
module tmo_timer
  import tmo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txDone,
  input  logic              rxStart,
  output logic              timerIrq,
  output logic              running,
  output logic [CNT_W-1:0]  count
);

  tmoStrobe_t       strobe;
  logic [PRE_W-1:0] prescale;
  logic [CNT_W-1:0] reload;
  logic             autoMode;
  logic             expire;

  tmo_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .txDone   (txDone),
    .rxStart  (rxStart),
    .expire   (expire),
    .strobe   (strobe),
    .prescale (prescale),
    .reload   (reload),
    .autoMode (autoMode),
    .timerIrq (timerIrq)
  );

  tmo_datapath #(
    .PRE_W(PRE_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .prescale (prescale),
    .reload   (reload),
    .count    (count),
    .running  (running),
    .expire   (expire)
  );

endmodule

// File: rtl/tmo_timer_chk.sv
module tmo_timer_chk
  import tmo_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [2:0]        cmdBits,
  input logic              txDone,
  input logic              rxStart,
  input logic              autoMode,
  input logic [CNT_W-1:0]  reload,
  input logic              timerIrq,
  input logic              running,
  input logic [CNT_W-1:0]  count
);

  logic cmdWr, startEv, haltEv, clrWr;
  assign cmdWr   = wrEn && (wrAddr == ADDR_W'(ADDR_CMD));
  assign startEv = (cmdWr && cmdBits[CMD_START_BIT]) || (autoMode && txDone);
  assign haltEv  = (cmdWr && cmdBits[CMD_STOP_BIT])  || (autoMode && rxStart);
  assign clrWr   = cmdWr && cmdBits[CMD_CLR_BIT];

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> (running && count == $past(reload)));                       // R2

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (haltEv && !startEv) |=> !running);                                     // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startEv) |=> $stable(count));                             // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (running && !startEv) |=> (count == $past(count) ||
                               count == $past(count) - CNT_W'(1)));         // R3

  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timerIrq) |-> (count == '0 && !running));                         // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !clrWr) |=> timerIrq);                                     // R8

  AST_IRQ_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timerIrq) |-> $past(clrWr));                                      // R8

endmodule

bind tmo_timer tmo_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .cmdBits  (wrData[2:0]),
  .txDone   (txDone),
  .rxStart  (rxStart),
  .autoMode (autoMode),
  .reload   (reload),
  .timerIrq (timerIrq),
  .running  (running),
  .count    (count)
);

// File: tb/test_tmo_timer.sv
module test_tmo_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        txDone = 1'b0;
  logic        rxStart = 1'b0;
  logic        timerIrq;
  logic        running;
  logic [15:0] count;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tmo_timer i_tmo_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txDone(txDone), .rxStart(rxStart),
    .timerIrq(timerIrq), .running(running), .count(count)
  );

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic pulseTx();
    txDone = 1'b1; @(negedge clk); txDone = 1'b0;
  endtask

  task automatic pulseRx();
    rxStart = 1'b1; @(negedge clk); rxStart = 1'b0;
  endtask

  task automatic testReset();
    checkVal("R1 irq", int'(timerIrq), 0);
    checkVal("R1 running", int'(running), 0);
    checkVal("R1 count", int'(count), 0);
  endtask

  task automatic testManual();
    // P=2 -> tick every 5 cycles, reload 3
    wr(1, 8'h00); wr(2, 2); wr(3, 0); wr(4, 3);
    wr(0, 8'h01);
    checkVal("R2 running", int'(running), 1);
    checkVal("R2 count", int'(count), 3);
    waitCyc(4);  checkVal("R3 before first tick", int'(count), 3);
    waitCyc(1);  checkVal("R3 first tick", int'(count), 2);
    waitCyc(9);  checkVal("R3 third tick pending", int'(count), 1);
    checkVal("R4 irq before zero", int'(timerIrq), 0);
    waitCyc(1);
    checkVal("R4 count zero", int'(count), 0);
    checkVal("R4 irq set", int'(timerIrq), 1);
    checkVal("R4 stopped", int'(running), 0);
    waitCyc(5);
    checkVal("R4 no reload", int'(count), 0);
    checkVal("R4 still stopped", int'(running), 0);
  endtask

  task automatic testClear();
    wr(0, 8'h00);
    checkVal("R8 zero write keeps irq", int'(timerIrq), 1);
    wr(0, 8'h04);
    checkVal("R8 w1c clears irq", int'(timerIrq), 0);
  endtask

  task automatic testAuto();
    // auto on, P=1 -> tick every 3 cycles, reload 10
    wr(1, 8'h80); wr(2, 1); wr(3, 0); wr(4, 10);
    pulseTx();
    checkVal("R5 auto start running", int'(running), 1);
    checkVal("R5 auto start count", int'(count), 10);
    waitCyc(6);
    checkVal("R3 two ticks at P=1", int'(count), 8);
    pulseRx();
    checkVal("R6 rx stops", int'(running), 0);
    checkVal("R6 count held", int'(count), 8);
    waitCyc(40);
    checkVal("R6 count still held", int'(count), 8);
    checkVal("R6 no timeout", int'(timerIrq), 0);
    // auto off: both pulses ignored
    wr(1, 8'h00);
    pulseTx();
    checkVal("R5 tx ignored running", int'(running), 0);
    checkVal("R5 tx ignored count", int'(count), 8);
    wr(0, 8'h01);
    pulseRx();
    checkVal("R6 rx ignored running", int'(running), 1);
    checkVal("R6 rx ignored count", int'(count), 10);
  endtask

  task automatic testStop();
    waitCyc(2);
    checkVal("R3 tick after restart", int'(count), 9);
    wr(0, 8'h02);
    checkVal("R7 stop running", int'(running), 0);
    checkVal("R7 stop count", int'(count), 9);
    waitCyc(10);
    checkVal("R7 count frozen", int'(count), 9);
  endtask

  task automatic testPriority();
    wr(0, 8'h03);
    checkVal("R9 start beats stop running", int'(running), 1);
    checkVal("R9 start beats stop count", int'(count), 10);
    // P=0 -> tick every cycle, reload 2
    wr(2, 0); wr(4, 2);
    wr(0, 8'h01);
    waitCyc(1);
    checkVal("R3 P=0 tick", int'(count), 1);
    wr(0, 8'h04);  // clear lands on the expiry edge
    checkVal("R9 expiry beats clear", int'(timerIrq), 1);
    checkVal("R9 count zero", int'(count), 0);
  endtask

  task automatic testZeroReload();
    wr(0, 8'h04);
    checkVal("R8 cleared again", int'(timerIrq), 0);
    wr(2, 2); wr(4, 0);
    wr(0, 8'h01);
    checkVal("R10 running at start", int'(running), 1);
    waitCyc(4);
    checkVal("R10 no irq before tick", int'(timerIrq), 0);
    waitCyc(1);
    checkVal("R10 irq at first tick", int'(timerIrq), 1);
    checkVal("R10 stopped", int'(running), 0);
    wr(0, 8'h01);
    checkVal("R8 irq kept over restart", int'(timerIrq), 1);
    checkVal("R8 restart runs", int'(running), 1);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    testReset();
    testManual();
    testClear();
    testAuto();
    testStop();
    testPriority();
    testZeroReload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule